// File: doc/BRIEF.md
# Serial audio bit-clock and master-clock prescaler

This block derives the timing for a serial audio master interface. It divides a source clock by a programmable integer ratio, odd ratios included. From that it produces a bit-clock level with a selectable idle polarity, a one-cycle strobe at each bit-period boundary and a one-cycle strobe at each channel-word boundary. It can also produce a master clock running at 256 times the sample rate. The source is either the local clock itself or a single-cycle tick that marks the edges of an external clock already brought into the local clock domain. The data shifter consumes the strobes and is not part of this block.

The ratio comes from a halved divider field and a separate odd bit. In the PCM framing the field holds the whole ratio instead of half of it. When the master clock is on, the prescaled rate is the master-clock rate, and a second stage counts master-clock periods per bit. The count per bit depends on the channel length so that one frame always spans 256 master-clock periods. When the master clock is off, the prescaled rate is the bit rate itself. Every counter is held at zero while the block is disabled.

Top module: `i2s_bclk_gen`

## Requirements
- R1: While the reset input is low, `bclk`, `bit_stb`, `word_stb` and `mclk` are all 0.
- R2: For `std_mode` values 0, 1 and 2 (the non-PCM framings), the source-tick ratio is R = 2*`div_field` + `odd_bit`. With `mclk_en` low and the local clock as the source, a bit period lasts R cycles and the first `bit_stb` comes R cycles after `enable` rises.
- R3: A `div_field` of 0 or 1 acts as 2, so R is never below 2 and `bit_stb` is never high in two consecutive cycles.
- R4: For `std_mode` = 3 (PCM), R = `div_field` + `odd_bit`, with the same clamp of the field to a minimum of 2.
- R5: With `mclk_en` high, `mclk` has a period of R source ticks and is high for ceil(R/2) of them. A bit period is then 8*R source ticks when `ch_long` is 0 (16-bit channels) and 4*R when `ch_long` is 1 (32-bit channels). With `mclk_en` low, `mclk` stays 0.
- R6: With `ext_sel` high, the counters advance only in cycles where `ext_tick` is high, so every period scales by the spacing of those ticks.
- R7: While disabled, `bclk` equals `cpol`. In each bit period `bclk` starts at `cpol`, moves to the opposite level for floor(R/2) source ticks at the end of the period (half of the period when `mclk_en` is high), and returns to `cpol` on the edge where `bit_stb` rises.
- R8: When `enable` falls, all counters clear. After `enable` rises again, the first bit period is full length, even if the previous one was cut off partway.
- R9: `word_stb` rises together with every 16th `bit_stb` when `ch_long` is 0 and every 32nd when `ch_long` is 1, counted from enable. It is never high without `bit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the divider; low holds every counter at zero |
| ext_sel | input | 1 | Selects the external tick as the divider source |
| ext_tick | input | 1 | Single-cycle pulse per external clock edge, local clock domain |
| div_field | input | 8 | Divider field (half ratio, or full ratio in PCM) |
| odd_bit | input | 1 | Adds one to the ratio |
| mclk_en | input | 1 | Enables the master clock output and the master-clock divide chain |
| ch_long | input | 1 | Channel length: 0 = 16 bits, 1 = 32 bits |
| std_mode | input | 2 | Framing: 0 Philips, 1 left-justified, 2 right-justified, 3 PCM |
| cpol | input | 1 | Idle level of the bit clock |
| bclk | output | 1 | Bit-clock level |
| bit_stb | output | 1 | One-cycle strobe at each bit-period boundary |
| word_stb | output | 1 | One-cycle strobe at each channel-word boundary |
| mclk | output | 1 | Master clock level, 0 when disabled |

## Verification
Every output is a register loaded from next-state logic. A change caused by the state reached at clock edge k is therefore visible right after edge k, and the bench samples on the falling edge that follows. The bench drives `enable` on a falling edge and counts rising edges from there. It expects the first `bit_stb` on the R-th edge (one bit period) and the first `word_stb` after 16 or 32 bit periods. The bit period, the `mclk` period and the number of cycles with `bclk` at its active level are measured between consecutive strobes or rising edges. That keeps the checks valid in external-tick mode, where the phase of the first tick is arbitrary.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;
  localparam int unsigned MCLK_PER_FS  = 256;
  localparam int unsigned CH_BITS_SHORT = 16;
  localparam int unsigned CH_BITS_LONG  = 32;
  // master-clock periods per bit: one frame holds two channels
  localparam int unsigned MPB_SHORT = MCLK_PER_FS / (2 * CH_BITS_SHORT);
  localparam int unsigned MPB_LONG  = MCLK_PER_FS / (2 * CH_BITS_LONG);
  localparam int unsigned MPB_W     = $clog2(MPB_SHORT);
  localparam int unsigned BITCNT_W  = $clog2(CH_BITS_LONG);

  typedef enum logic [1:0] {
    FMT_PHILIPS = 2'd0,
    FMT_LEFT    = 2'd1,
    FMT_RIGHT   = 2'd2,
    FMT_PCM     = 2'd3
  } frame_fmt_e;
endpackage

// File: rtl/i2s_ratio_sel.sv
module i2s_ratio_sel #(
  parameter int DIV_W = 8,
  parameter int RW    = DIV_W + 2
) (
  input  logic [DIV_W-1:0] div_field,
  input  logic             odd_bit,
  input  logic             pcm,
  output logic [RW-1:0]    ratio
);
  logic [RW-1:0] field_eff;

  always_comb begin
    // a field below 2 would stop the clock or pass the source through
    if (div_field < DIV_W'(2)) field_eff = RW'(2);
    else                       field_eff = RW'(div_field);
    if (pcm) ratio = field_eff + RW'(odd_bit);
    else     ratio = (field_eff << 1) + RW'(odd_bit);
  end
endmodule

// File: rtl/i2s_pre_div.sv
module i2s_pre_div #(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          mclk_en,
  input  logic [RW-1:0] ratio,
  output logic          wrap,
  output logic [RW-1:0] cnt_nxt,
  output logic          mclk_o
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] hi_len;
  logic          mclk_nxt;

  always_comb begin
    hi_len = ratio - (ratio >> 1);
    wrap   = en & tick & (cnt_q >= ratio - RW'(1));
    if (!en)       cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else if (tick) cnt_nxt = cnt_q + RW'(1);
    else           cnt_nxt = cnt_q;
    mclk_nxt = en & mclk_en & (cnt_nxt < hi_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mclk_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      mclk_o <= mclk_nxt;
    end
  end

  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt_q == '0));

  a_r5_mclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |=> !mclk_o);
endmodule

// File: rtl/i2s_bit_div.sv
module i2s_bit_div
  import i2s_clk_pkg::*;
#(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pre_wrap,
  input  logic [RW-1:0] pre_cnt_nxt,
  input  logic [RW-1:0] ratio,
  input  logic          mclk_en,
  input  logic          ch_long,
  input  logic          cpol,
  output logic          bclk_o,
  output logic          bit_stb_o,
  output logic          word_stb_o
);
  logic [MPB_W-1:0]    sub_q, sub_nxt, sub_last, sub_half;
  logic [BITCNT_W-1:0] bcnt_q, bcnt_nxt, bcnt_last;
  logic [RW-1:0]       hi_len;
  logic                bit_end, word_end, active_half, bclk_nxt;

  always_comb begin
    sub_last  = ch_long ? MPB_W'(MPB_LONG - 1) : MPB_W'(MPB_SHORT - 1);
    sub_half  = ch_long ? MPB_W'(MPB_LONG / 2) : MPB_W'(MPB_SHORT / 2);
    bcnt_last = ch_long ? BITCNT_W'(CH_BITS_LONG - 1) : BITCNT_W'(CH_BITS_SHORT - 1);
    hi_len    = ratio - (ratio >> 1);

    if (mclk_en) bit_end = pre_wrap & (sub_q >= sub_last);
    else         bit_end = pre_wrap;

    if (!en || !mclk_en)    sub_nxt = '0;
    else if (bit_end)       sub_nxt = '0;
    else if (pre_wrap)      sub_nxt = sub_q + MPB_W'(1);
    else                    sub_nxt = sub_q;

    word_end = bit_end & (bcnt_q >= bcnt_last);
    if (!en)           bcnt_nxt = '0;
    else if (word_end) bcnt_nxt = '0;
    else if (bit_end)  bcnt_nxt = bcnt_q + BITCNT_W'(1);
    else               bcnt_nxt = bcnt_q;

    if (mclk_en) active_half = (sub_nxt >= sub_half);
    else         active_half = (pre_cnt_nxt >= hi_len);
    bclk_nxt = cpol ^ (en & active_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q      <= '0;
      bcnt_q     <= '0;
      bclk_o     <= 1'b0;
      bit_stb_o  <= 1'b0;
      word_stb_o <= 1'b0;
    end else begin
      sub_q      <= sub_nxt;
      bcnt_q     <= bcnt_nxt;
      bclk_o     <= bclk_nxt;
      bit_stb_o  <= bit_end;
      word_stb_o <= word_end;
    end
  end

  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bclk_o == $past(cpol)));

  a_r9_word_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> bit_stb_o);

  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen
  import i2s_clk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ext_sel,
  input  logic             ext_tick,
  input  logic [DIV_W-1:0] div_field,
  input  logic             odd_bit,
  input  logic             mclk_en,
  input  logic             ch_long,
  input  logic [1:0]       std_mode,
  input  logic             cpol,
  output logic             bclk,
  output logic             bit_stb,
  output logic             word_stb,
  output logic             mclk
);
  localparam int RW = DIV_W + 2;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          src_tick, pcm, pre_wrap;
  logic [RW-1:0] ratio, pre_cnt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign src_tick = ext_sel ? ext_tick : 1'b1;
  assign pcm      = (frame_fmt_e'(std_mode) == FMT_PCM);

  i2s_ratio_sel #(.DIV_W(DIV_W), .RW(RW)) u_ratio (
    .div_field (div_field),
    .odd_bit   (odd_bit),
    .pcm       (pcm),
    .ratio     (ratio)
  );

  i2s_pre_div #(.RW(RW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (enable),
    .tick    (src_tick),
    .mclk_en (mclk_en),
    .ratio   (ratio),
    .wrap    (pre_wrap),
    .cnt_nxt (pre_cnt_nxt),
    .mclk_o  (mclk)
  );

  i2s_bit_div #(.RW(RW)) u_bit (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en          (enable),
    .pre_wrap    (pre_wrap),
    .pre_cnt_nxt (pre_cnt_nxt),
    .ratio       (ratio),
    .mclk_en     (mclk_en),
    .ch_long     (ch_long),
    .cpol        (cpol),
    .bclk_o      (bclk),
    .bit_stb_o   (bit_stb),
    .word_stb_o  (word_stb)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!bclk && !bit_stb && !word_stb && !mclk));
endmodule

// File: tb/i2s_bclk_gen_tb_top.sv
module i2s_bclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {div[7:0], odd, std[1:0], mclk_en, ch_long, ext_sel}
  localparam logic [13:0] VEC [NV] = '{
    {8'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'd2, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0},
    {8'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'd1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
    {8'd5, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'd1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'd2, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'd3, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0},
    {8'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1},
    {8'd2, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, enable, ext_sel, ext_tick, odd_bit, mclk_en, ch_long, cpol;
  logic [7:0] div_field;
  logic [1:0] std_mode;
  logic bclk, bit_stb, word_stb, mclk;
  int checks = 0;
  int errors = 0;
  int ext_ctr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    ext_ctr  <= (ext_ctr == 2) ? 0 : ext_ctr + 1;
    ext_tick <= (ext_ctr == 2);
  end

  i2s_bclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_sel(ext_sel),
    .ext_tick(ext_tick), .div_field(div_field), .odd_bit(odd_bit),
    .mclk_en(mclk_en), .ch_long(ch_long), .std_mode(std_mode), .cpol(cpol),
    .bclk(bclk), .bit_stb(bit_stb), .word_stb(word_stb), .mclk(mclk)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_ratio(int d, int o, int s);
    int de = (d < 2) ? 2 : d;
    return (s == 3) ? de + o : 2 * de + o;
  endfunction

  task automatic run_case(logic [13:0] v, logic pol);
    int r, m, p, s1, s2, act, r2, r3, rises, bad;
    logic pm;
    string tag;
    @(negedge clk);
    enable = 0; div_field = v[13:6]; odd_bit = v[5]; std_mode = v[4:3];
    mclk_en = v[2]; ch_long = v[1]; ext_sel = v[0]; cpol = pol;
    repeat (3) @(negedge clk);
    chk("R7 idle level", int'(bclk), int'(pol));
    r = ref_ratio(int'(v[13:6]), int'(v[5]), int'(v[4:3]));
    m = v[0] ? 3 : 1;
    p = r * m * (v[2] ? (v[1] ? 4 : 8) : 1);
    if (v[0]) tag = "R6";
    else if (v[2]) tag = "R5";
    else if (v[4:3] == 2'd3) tag = "R4";
    else if (v[13:6] < 2) tag = "R3";
    else tag = "R2";
    s1 = -1; s2 = -1; act = 0; r2 = 0; r3 = 0; rises = 0; bad = 0; pm = mclk;
    enable = 1;
    for (int c = 1; c <= 3 * p + 8; c++) begin
      @(negedge clk);
      if (s1 >= 0 && s2 < 0 && bclk != pol) act++;
      if (bit_stb) begin
        if (s1 < 0) s1 = c;
        else if (s2 < 0) s2 = c;
      end
      if (mclk && !pm) begin
        rises++;
        if (rises == 2) r2 = c;
        if (rises == 3) r3 = c;
      end
      if (!v[2] && mclk) bad++;
      pm = mclk;
    end
    if (!v[0]) chk({tag, " first strobe latency"}, s1, p);
    chk({tag, " bit period"}, s2 - s1, p);
    chk({"R7 active bclk cycles ", tag}, act, v[2] ? p / 2 : (r / 2) * m);
    if (v[2]) chk({"R5 mclk period ", tag}, r3 - r2, r * m);
    else      chk({"R5 mclk held low ", tag}, bad, 0);
    enable = 0;
  endtask

  task automatic word_case(logic lng);
    int first, nb, bits, bad;
    @(negedge clk);
    enable = 0; div_field = 8'd2; odd_bit = 0; std_mode = 2'd0;
    mclk_en = 0; ch_long = lng; ext_sel = 0; cpol = 0;
    repeat (2) @(negedge clk);
    enable = 1; first = -1; nb = 0; bits = -1; bad = 0;
    for (int c = 1; c <= 300; c++) begin
      @(negedge clk);
      if (word_stb && !bit_stb) bad++;
      if (bit_stb) nb++;
      if (word_stb) begin
        if (first < 0) begin first = c; nb = 0; end
        else if (bits < 0) bits = nb;
      end
    end
    chk("R9 first word strobe", first, lng ? 128 : 64);
    chk("R9 bits per word", bits, lng ? 32 : 16);
    chk("R9 word without bit strobe", bad, 0);
    enable = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s;
    rst_n = 0; enable = 1; ext_sel = 0; div_field = 8'd2; odd_bit = 0;
    std_mode = 0; mclk_en = 1; ch_long = 0; cpol = 1;
    repeat (3) @(negedge clk);
    chk("R1 bclk in reset", int'(bclk), 0);
    chk("R1 bit_stb in reset", int'(bit_stb), 0);
    chk("R1 word_stb in reset", int'(word_stb), 0);
    chk("R1 mclk in reset", int'(mclk), 0);
    enable = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run_case(VEC[i], logic'(i % 2));

    word_case(1'b0);
    word_case(1'b1);

    // R8: cut a period short, then restart
    @(negedge clk);
    div_field = 8'd3; odd_bit = 0; std_mode = 0; mclk_en = 0; ext_sel = 0; cpol = 1;
    enable = 1;
    repeat (3) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk("R8 no strobe while disabled", int'(bit_stb), 0);
    chk("R7 bclk idle after disable", int'(bclk), 1);
    enable = 1;
    s = -1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (bit_stb && s < 0) s = c;
    end
    chk("R8 full first period after restart", s, 6);
    enable = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule